// File: doc/BRIEF.md
# Read completion timeout tracker

This block sits beside the requester of a root-complex-side port and watches each non-posted read it sends to an endpoint. Each read is named by a small tag. A slot for that tag starts counting prescaled timebase ticks when the read is issued, and stops when the matching completion returns. While any read is still waiting for its completion, the requester is held in a stall.

If the programmed number of ticks passes with no completion, the slot retires the tag and releases its share of the stall. It then records a completion-timeout error in three sticky status words. The first is an uncorrectable-error word. The second is a device-status word. The third is a root-error word, which is only updated when software has enabled non-fatal reporting. A completion that arrives after its tag was retired is discarded. Software clears the status words by writing ones to the bits it wants cleared.

Top module: `cpl_timeout_tracker`

## Requirements
- R1: `stall` is 1 from the cycle after a read is issued, for as long as any tag is outstanding. It returns to 0 in the cycle after the last outstanding tag completes or times out.
- R2: A tag times out on the TIMEOUT_TICKS-th `tick` after its issue. A tick in the issue cycle is not counted. When a completion for that tag arrives in the same cycle as the expiring tick, the completion wins and no error is recorded.
- R3: A timeout sets bit 14 of `unc_status` and leaves every other bit of that word at 0.
- R4: A timeout sets bit 1 of `dev_status`, the non-fatal error detected flag. Bits 0, 2 and 3 stay 0.
- R5: When `root_cmd` bit 1 is set, a timeout sets `root_status` bits 2 and 5, giving 0x24. If bit 2 is already set, or if two or more tags time out in the same cycle, bit 3 is also set, giving 0x2C.
- R6: When `root_cmd` bit 1 is clear, a timeout leaves `root_status` unchanged, while R3 and R4 still apply.
- R7: A completion that arrives before expiry retires the tag and releases the stall. It changes no status bit.
- R8: The following are discarded, with no effect on `stall`, on the status words or on the tag's counter: a completion for a tag that is not outstanding (never issued, or already timed out), and an issue for a tag that is already outstanding.
- R9: The status bits are sticky. A cycle with `clr_wr`=1 clears the bits set in `clr_data` in the word chosen by `clr_sel` (0 = `unc_status`, 1 = `dev_status`, 2 = `root_status`). A timeout in the same cycle wins over the clear.
- R10: After reset, `stall` is 0 and all three status words are 0.
- R11: Up to NUM_TAGS tags are tracked at once, each with its own counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | A non-posted read is issued this cycle |
| req_tag | input | TAG_W | Tag of the issued read |
| cpl_valid | input | 1 | A completion arrives this cycle |
| cpl_tag | input | TAG_W | Tag carried by the completion |
| tick | input | 1 | Prescaled timebase tick |
| root_cmd | input | 3 | Root reporting enables: bit0 correctable, bit1 non-fatal, bit2 fatal |
| clr_wr | input | 1 | Write-1-to-clear strobe |
| clr_sel | input | 2 | Word to clear: 0 uncorrectable, 1 device, 2 root |
| clr_data | input | 32 | Mask of bits to clear |
| stall | output | 1 | Requester hold while any read is outstanding |
| unc_status | output | 32 | Uncorrectable error status word |
| dev_status | output | 4 | Device status error flags |
| root_status | output | 32 | Root error status word |

## Verification
The in-line properties check on every cycle that the stall only rises after an issue. They also check that it only falls after a completion or a tick, that no counter passes its limit, and that a re-issue of a busy tag freezes its counter. Further per-cycle properties cover the status words: set bits stay set unless cleared, a timeout bit in the uncorrectable word always comes with the device flag, and root bits rise only under the non-fatal enable. Only the bench scenarios can show the exact tick on which expiry happens and the win of a completion on that tick. The same holds for the 0x24 and 0x2C root values across repeated and simultaneous timeouts, and for the discard of late completions.

// File: rtl/cto_pkg.sv
// Package: shared encodings for the completion timeout tracker.
// Assumes 32-bit status words; bit positions are fixed by the decoders
// that read the words.
package cto_pkg;
    typedef enum logic [1:0] {
        SEL_UNC  = 2'd0,
        SEL_DEV  = 2'd1,
        SEL_ROOT = 2'd2
    } clr_sel_e;

    localparam int STAT_W             = 32;
    localparam int DEV_W              = 4;
    localparam int UNC_CPL_TMO_BIT    = 14;
    localparam int DEV_NONFATAL_BIT   = 1;
    localparam int ROOT_UNC_RCVD_BIT  = 2;
    localparam int ROOT_UNC_MULT_BIT  = 3;
    localparam int ROOT_NF_RCVD_BIT   = 5;
    localparam int CMD_NONFATAL_EN    = 1;
endpackage

// File: rtl/cto_tag_slot.sv
// Module: one tag slot. It holds a busy flag and a tick counter that is
// started at issue. It retires the tag on completion or on expiry.
// Assumes issue and completion strobes are already decoded to this tag.
module cto_tag_slot #(
    parameter int TIMEOUT_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    input  logic cpl,
    input  logic tick,
    output logic busy,
    output logic expire
);
    localparam int CNT_W = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_TICKS - 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;

    // Expiry: the last tick arrives while busy; a completion in the same cycle wins.
    always_comb begin
        expire = busy_q && tick && !cpl && (cnt_q == LAST);
    end

    // Slot state: start on issue, retire on completion or expiry, count ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (issue) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
            end
        end else if (cpl || expire) begin
            busy_q <= 1'b0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign busy = busy_q;

    // R2: the counter never passes the expiry limit.
    a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (cnt_q <= LAST));

    // R8: a re-issue of a busy tag does not restart its counter.
    a_r8_reissue_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && issue && !cpl && !tick) |=> (busy_q && cnt_q == $past(cnt_q)));
endmodule

// File: rtl/cto_err_log.sv
// Module: sticky error status words. It records completion timeouts in the
// uncorrectable, device and root words. Software clears bits by writing 1s.
// Assumes expire pulses last one cycle each; a set wins over a clear.
module cto_err_log
    import cto_pkg::*;
#(
    parameter int NUM_TAGS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAGS-1:0] expire,
    input  logic [2:0]          root_cmd,
    input  logic                clr_wr,
    input  logic [1:0]          clr_sel,
    input  logic [STAT_W-1:0]   clr_data,
    output logic [STAT_W-1:0]   unc_status,
    output logic [DEV_W-1:0]    dev_status,
    output logic [STAT_W-1:0]   root_status
);
    localparam int NCNT_W = $clog2(NUM_TAGS + 1);

    logic [STAT_W-1:0] unc_q, root_q;
    logic [DEV_W-1:0]  dev_q;
    logic [NCNT_W-1:0] n_exp;
    logic              any_exp;
    logic [STAT_W-1:0] unc_set, unc_clr, root_set, root_clr;
    logic [DEV_W-1:0]  dev_set, dev_clr;

    // Count the tags that expire in this cycle.
    always_comb begin
        n_exp = '0;
        for (int i = 0; i < NUM_TAGS; i++) begin
            n_exp = n_exp + NCNT_W'(expire[i]);
        end
        any_exp = (n_exp != '0);
    end

    // Set masks for a timeout and clear masks for a software write.
    always_comb begin
        unc_set  = '0;
        dev_set  = '0;
        root_set = '0;
        if (any_exp) begin
            unc_set[UNC_CPL_TMO_BIT]  = 1'b1;
            dev_set[DEV_NONFATAL_BIT] = 1'b1;
            if (root_cmd[CMD_NONFATAL_EN]) begin
                root_set[ROOT_UNC_RCVD_BIT] = 1'b1;
                root_set[ROOT_NF_RCVD_BIT]  = 1'b1;
                root_set[ROOT_UNC_MULT_BIT] = root_q[ROOT_UNC_RCVD_BIT] || (n_exp > NCNT_W'(1));
            end
        end
        unc_clr  = (clr_wr && clr_sel == SEL_UNC)  ? clr_data : '0;
        dev_clr  = (clr_wr && clr_sel == SEL_DEV)  ? clr_data[DEV_W-1:0] : '0;
        root_clr = (clr_wr && clr_sel == SEL_ROOT) ? clr_data : '0;
    end

    // Status registers: clear the written bits, then apply the new errors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            unc_q  <= '0;
            dev_q  <= '0;
            root_q <= '0;
        end else begin
            unc_q  <= (unc_q  & ~unc_clr)  | unc_set;
            dev_q  <= (dev_q  & ~dev_clr)  | dev_set;
            root_q <= (root_q & ~root_clr) | root_set;
        end
    end

    assign unc_status  = unc_q;
    assign dev_status  = dev_q;
    assign root_status = root_q;

    // R9: the timeout bit stays set unless a clear hits it.
    a_r9_sticky_unc: assert property (@(posedge clk) disable iff (!rst_n)
        (unc_q[UNC_CPL_TMO_BIT] && !(clr_wr && clr_sel == SEL_UNC && clr_data[UNC_CPL_TMO_BIT]))
        |=> unc_q[UNC_CPL_TMO_BIT]);

    // R4: a new timeout bit is always joined by the device non-fatal flag.
    a_r4_dev_with_unc: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unc_q[UNC_CPL_TMO_BIT]) |-> dev_q[DEV_NONFATAL_BIT]);

    // R6: root bits rise only under the non-fatal reporting enable.
    a_r6_root_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(root_q[ROOT_NF_RCVD_BIT]) |-> $past(root_cmd[CMD_NONFATAL_EN]));
endmodule

// File: rtl/cpl_timeout_tracker.sv
// Module: top of the completion timeout tracker. It decodes the issue and
// completion tags to one slot per tag, stalls the requester while any slot
// is busy, and feeds the expiries to the sticky status words.
// Assumes one issue and one completion at most per cycle.
module cpl_timeout_tracker
    import cto_pkg::*;
#(
    parameter int NUM_TAGS      = 4,
    parameter int TIMEOUT_TICKS = 50,
    parameter int TAG_W         = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic              cpl_valid,
    input  logic [TAG_W-1:0]  cpl_tag,
    input  logic              tick,
    input  logic [2:0]        root_cmd,
    input  logic              clr_wr,
    input  logic [1:0]        clr_sel,
    input  logic [31:0]       clr_data,
    output logic              stall,
    output logic [31:0]       unc_status,
    output logic [3:0]        dev_status,
    output logic [31:0]       root_status
);
    logic [NUM_TAGS-1:0] busy, expire, issue_hit, cpl_hit;

    // Decode the issue and completion strobes to per-tag hits.
    always_comb begin
        for (int i = 0; i < NUM_TAGS; i++) begin
            issue_hit[i] = req_valid && (req_tag == TAG_W'(i));
            cpl_hit[i]   = cpl_valid && (cpl_tag == TAG_W'(i));
        end
    end

    for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
        cto_tag_slot #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .issue  (issue_hit[g]),
            .cpl    (cpl_hit[g]),
            .tick   (tick),
            .busy   (busy[g]),
            .expire (expire[g])
        );
    end

    assign stall = |busy;

    cto_err_log #(.NUM_TAGS(NUM_TAGS)) u_log (
        .clk         (clk),
        .rst_n       (rst_n),
        .expire      (expire),
        .root_cmd    (root_cmd),
        .clr_wr      (clr_wr),
        .clr_sel     (clr_sel),
        .clr_data    (clr_data),
        .unc_status  (unc_status),
        .dev_status  (dev_status),
        .root_status (root_status)
    );

    // R1: the stall rises only after an issue.
    a_r1_stall_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stall) |-> $past(req_valid));

    // R1: the stall falls only after a completion or a tick.
    a_r1_stall_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stall) |-> $past(cpl_valid || tick));
endmodule

// File: tb/cpl_timeout_tracker_tb.sv
module cpl_timeout_tracker_tb;
    localparam int NT = 4;
    localparam int T  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_tag = '0;
    logic        cpl_valid = 1'b0;
    logic [1:0]  cpl_tag = '0;
    logic        tick = 1'b0;
    logic [2:0]  root_cmd = 3'b111;
    logic        clr_wr = 1'b0;
    logic [1:0]  clr_sel = '0;
    logic [31:0] clr_data = '0;
    logic        stall;
    logic [31:0] unc_status, root_status;
    logic [3:0]  dev_status;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cpl_timeout_tracker #(.NUM_TAGS(NT), .TIMEOUT_TICKS(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_tag(req_tag),
        .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .tick(tick), .root_cmd(root_cmd),
        .clr_wr(clr_wr), .clr_sel(clr_sel), .clr_data(clr_data), .stall(stall),
        .unc_status(unc_status), .dev_status(dev_status), .root_status(root_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
        req_valid = 0; cpl_valid = 0; tick = 0; clr_wr = 0;
    endtask

    task automatic issue(input int t);
        req_valid = 1; req_tag = 2'(t); cyc();
    endtask

    task automatic cpl(input int t);
        cpl_valid = 1; cpl_tag = 2'(t); cyc();
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1; cyc();
        end
    endtask

    task automatic clear(input int sel, input logic [31:0] m);
        clr_wr = 1; clr_sel = 2'(sel); clr_data = m; cyc();
    endtask

    task automatic clear_all();
        clear(0, '1); clear(1, '1); clear(2, '1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cyc();
        // R10: reset state
        chk("R10 stall", 32'(stall), 0);
        chk("R10 unc", unc_status, 0);
        chk("R10 dev", 32'(dev_status), 0);
        chk("R10 root", root_status, 0);

        // R2 R3 R4 R5 R7 R8: sweep every tag and every completion delay
        for (int t = 0; t < NT; t++) begin
            for (int d = 0; d <= T + 1; d++) begin
                clear_all();
                issue(t);
                chk("R1 stall after issue", 32'(stall), 1);
                ticks(d);
                chk("R2 stall before cpl", 32'(stall), (d < T) ? 1 : 0);
                chk("R3 unc after delay", unc_status, (d >= T) ? 32'h4000 : 0);
                chk("R4 dev after delay", 32'(dev_status), (d >= T) ? 2 : 0);
                chk("R5 root after delay", root_status, (d >= T) ? 32'h24 : 0);
                cpl(t);
                chk("R7 stall after cpl", 32'(stall), 0);
                chk("R8 unc after late cpl", unc_status, (d >= T) ? 32'h4000 : 0);
            end
        end

        // R8: completion for a never-issued tag
        clear_all();
        cpl(2);
        chk("R8 stray cpl stall", 32'(stall), 0);
        chk("R8 stray cpl unc", unc_status, 0);

        // R2: completion on the expiring tick wins
        issue(1);
        ticks(T - 1);
        tick = 1; cpl_valid = 1; cpl_tag = 2'd1; cyc();
        chk("R2 same-cycle cpl stall", 32'(stall), 0);
        chk("R2 same-cycle cpl unc", unc_status, 0);

        // R2: tick in the issue cycle is not counted
        tick = 1; issue(3);
        ticks(T - 1);
        chk("R2 issue-cycle tick stall", 32'(stall), 1);
        ticks(1);
        chk("R2 issue-cycle tick unc", unc_status, 32'h4000);

        // R5: repeated timeouts
        clear_all();
        issue(0); ticks(T);
        chk("R5 first root", root_status, 32'h24);
        issue(1); ticks(T);
        chk("R5 second root", root_status, 32'h2C);
        clear(2, 32'h4);
        chk("R9 partial clear root", root_status, 32'h28);
        issue(2); ticks(T);
        chk("R5 third root", root_status, 32'h2C);

        // R5 R11: two tags expire in the same cycle
        clear_all();
        issue(0); issue(1);
        ticks(T);
        chk("R5 simultaneous root", root_status, 32'h2C);
        chk("R11 simultaneous stall", 32'(stall), 0);

        // R6: reporting disabled
        clear_all();
        root_cmd = 3'b101;
        issue(2); ticks(T);
        chk("R6 root disabled", root_status, 0);
        chk("R6 unc still set", unc_status, 32'h4000);
        chk("R6 dev still set", 32'(dev_status), 2);
        root_cmd = 3'b111;

        // R8: re-issue of a busy tag does not restart it
        clear_all();
        issue(2); ticks(2); issue(2); ticks(T - 2);
        chk("R8 reissue stall", 32'(stall), 0);
        chk("R8 reissue unc", unc_status, 32'h4000);

        // R9: set wins over a clear in the same cycle, and bits stay sticky
        clear_all();
        issue(0); ticks(T - 1);
        tick = 1; clr_wr = 1; clr_sel = 2'd0; clr_data = '1; cyc();
        chk("R9 set beats clear", unc_status, 32'h4000);
        ticks(3);
        chk("R9 sticky unc", unc_status, 32'h4000);
        clear(1, '1);
        chk("R9 clear dev", 32'(dev_status), 0);
        chk("R9 dev clear spares unc", unc_status, 32'h4000);
        clear(0, '1);
        chk("R9 clear unc", unc_status, 0);

        // R11 R1: all tags outstanding at once
        clear_all();
        for (int t = 0; t < NT; t++) issue(t);
        ticks(T - 1);
        for (int t = 0; t < NT - 1; t++) cpl(t);
        chk("R11 one left stall", 32'(stall), 1);
        chk("R11 one left unc", unc_status, 0);
        ticks(1);
        chk("R11 last expired stall", 32'(stall), 0);
        chk("R11 last expired unc", unc_status, 32'h4000);
        chk("R5 single expiry root", root_status, 32'h24);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule